// File: doc/BRIEF.md
# Shift-then-Saturate Arithmetic Unit

This unit takes a 32-bit two's-complement operand and first applies an optional shift to it, either an arithmetic right shift or a logical left shift by an immediate amount. It then clamps the shifted value to an n-bit range chosen at run time. The range is signed or unsigned according to a mode select. The result is registered, so it appears one clock after the operand is presented.

A saturation flag reports that clamping changed the value. An encoding-error output flags operand fields that lie outside their legal ranges. Those fields are still handled by a fixed substitution rule. The unit sits in an execute stage. Instruction decode, condition evaluation, register access and any sticky status storage belong to the surrounding pipeline.

Top module: `shsat_unit`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `result`, `sat_flag` and `enc_err` are all 0.
- R2: An operand presented with `in_valid` high at a rising edge produces `out_valid` high, together with its `result`, `sat_flag` and `enc_err`, after that same edge. A cycle without `in_valid` drives `out_valid` low and leaves `result` unchanged.
- R3: In signed mode (`sat_unsigned`=0), a shifted value below -2^(n-1) gives -2^(n-1). A shifted value above 2^(n-1)-1 gives 2^(n-1)-1.
- R4: In unsigned mode (`sat_unsigned`=1), any negative shifted value gives 0. A shifted value above 2^n-1 gives 2^n-1.
- R5: A shifted value already inside the selected range appears unchanged on `result`, with `sat_flag` low.
- R6: With `shift_dir`=1, the operand is shifted right arithmetically by `shift_amt` (1..31) before clamping. The sign bit is replicated into the vacated positions.
- R7: With `shift_dir`=0, the operand is shifted left logically by `shift_amt` (0..31). The low 32 bits of that shift are read as a signed value before clamping.
- R8: In unsigned mode with n=0, every operand gives `result` 0. `sat_flag` is set exactly when the shifted value is nonzero.
- R9: In signed mode with n=32, `result` equals the shifted value and `sat_flag` stays low.
- R10: A right shift with `shift_amt`=0 is performed as no shift. A signed n of 0 is performed as n=1. A signed n above 32 is performed as n=32. An unsigned n above 31 is performed as n=31. Each of these cases sets `enc_err`. Legal fields leave `enc_err` low.
- R11: `sat_flag` is high exactly when `result` differs from the shifted intermediate value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| operand | input | 32 | Signed value to shift and clamp |
| sat_unsigned | input | 1 | 0: signed range, 1: unsigned range |
| sat_width | input | 6 | Saturation width n |
| shift_dir | input | 1 | 0: logical left, 1: arithmetic right |
| shift_amt | input | 5 | Shift distance |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| result | output | 32 | Clamped value |
| sat_flag | output | 1 | Clamping altered the shifted value |
| enc_err | output | 1 | An illegal shift or width was substituted |

## Verification
Some combinations are hard to reach with ordinary operands. The hardest is a left shift that carries bits past bit 31 and flips the apparent sign, so that the clamp has to act on the wrapped value. The stimulus reaches this with operands such as 0x4000_0001 shifted left by one and by two, in both modes. The stimulus also covers both edges of the width range, including unsigned n=0 and signed n=32, and the illegal encodings on either side of those edges.

// File: rtl/shsat_pkg.sv
package shsat_pkg;
  typedef enum logic {
    SHIFT_LEFT  = 1'b0,
    SHIFT_RIGHT = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/shsat_legalize.sv
module shsat_legalize #(
  parameter int DATA_W  = 32,
  parameter int NPOS_W  = $clog2(DATA_W) + 1,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               sat_unsigned,
  input  logic [NPOS_W-1:0]  width_raw,
  input  logic               dir_right,
  input  logic [SHAMT_W-1:0] amt_raw,
  output logic [NPOS_W-1:0]  width_eff,
  output logic               shift_en,
  output logic               err
);
  localparam logic [NPOS_W-1:0] SGN_MAX = NPOS_W'(DATA_W);
  localparam logic [NPOS_W-1:0] UNS_MAX = NPOS_W'(DATA_W - 1);

  logic width_bad;
  logic amt_bad;

  always_comb begin
    width_eff = width_raw;
    width_bad = 1'b0;
    if (sat_unsigned) begin
      if (width_raw > UNS_MAX) begin
        width_eff = UNS_MAX;
        width_bad = 1'b1;
      end
    end else begin
      if (width_raw == '0) begin
        width_eff = NPOS_W'(1);
        width_bad = 1'b1;
      end else if (width_raw > SGN_MAX) begin
        width_eff = SGN_MAX;
        width_bad = 1'b1;
      end
    end
  end

  // a zero-distance right shift is not a legal encoding: perform no shift
  assign amt_bad  = dir_right && (amt_raw == '0);
  assign shift_en = !amt_bad;
  assign err      = width_bad || amt_bad;
endmodule

// File: rtl/shsat_shifter.sv
module shsat_shifter
  import shsat_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  din,
  input  shift_dir_e         dir,
  input  logic               enable,
  input  logic [SHAMT_W-1:0] amt,
  output logic [DATA_W-1:0]  dout
);
  logic [DATA_W-1:0] left_val;
  logic [DATA_W-1:0] right_val;

  // the left shift keeps only the low DATA_W bits; overflow is discarded
  assign left_val  = din << amt;
  assign right_val = DATA_W'($signed(din) >>> amt);

  always_comb begin
    if (!enable) begin
      dout = din;
    end else if (dir == SHIFT_RIGHT) begin
      dout = right_val;
    end else begin
      dout = left_val;
    end
  end
endmodule

// File: rtl/shsat_clamp.sv
module shsat_clamp #(
  parameter int DATA_W = 32,
  parameter int NPOS_W = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] din,
  input  logic              sat_unsigned,
  input  logic [NPOS_W-1:0] width,
  output logic [DATA_W-1:0] dout,
  output logic              clipped
);
  localparam int EXT_W = DATA_W + 2;

  logic signed [EXT_W-1:0] val;
  logic signed [EXT_W-1:0] bound;
  logic signed [EXT_W-1:0] hi;
  logic signed [EXT_W-1:0] lo;
  logic signed [EXT_W-1:0] sel;
  logic [NPOS_W-1:0]       exp_pos;

  assign val     = {{2{din[DATA_W-1]}}, din};
  assign exp_pos = sat_unsigned ? width : (width - NPOS_W'(1));
  assign bound   = EXT_W'(1) <<< exp_pos;
  assign hi      = bound - EXT_W'(1);
  assign lo      = sat_unsigned ? '0 : -bound;

  always_comb begin
    if (val > hi) begin
      sel = hi;
    end else if (val < lo) begin
      sel = lo;
    end else begin
      sel = val;
    end
  end

  assign dout    = sel[DATA_W-1:0];
  assign clipped = (sel != val);
endmodule

// File: rtl/shsat_unit.sv
module shsat_unit
  import shsat_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int NPOS_W  = $clog2(DATA_W) + 1,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [DATA_W-1:0]  operand,
  input  logic               sat_unsigned,
  input  logic [NPOS_W-1:0]  sat_width,
  input  logic               shift_dir,
  input  logic [SHAMT_W-1:0] shift_amt,
  output logic               out_valid,
  output logic [DATA_W-1:0]  result,
  output logic               sat_flag,
  output logic               enc_err
);
  logic [NPOS_W-1:0] width_eff;
  logic              shift_en;
  logic              err_c;
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] clamped;
  logic              clip_c;
  shift_dir_e        dir_e;

  logic              valid_q, valid_d;
  logic [DATA_W-1:0] result_q, result_d;
  logic              flag_q, flag_d;
  logic              err_q, err_d;

  assign dir_e = shift_dir_e'(shift_dir);

  shsat_legalize #(.DATA_W(DATA_W), .NPOS_W(NPOS_W), .SHAMT_W(SHAMT_W)) u_legal (
    .sat_unsigned (sat_unsigned),
    .width_raw    (sat_width),
    .dir_right    (shift_dir),
    .amt_raw      (shift_amt),
    .width_eff    (width_eff),
    .shift_en     (shift_en),
    .err          (err_c)
  );

  shsat_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .din    (operand),
    .dir    (dir_e),
    .enable (shift_en),
    .amt    (shift_amt),
    .dout   (shifted)
  );

  shsat_clamp #(.DATA_W(DATA_W), .NPOS_W(NPOS_W)) u_clamp (
    .din          (shifted),
    .sat_unsigned (sat_unsigned),
    .width        (width_eff),
    .dout         (clamped),
    .clipped      (clip_c)
  );

  always_comb begin
    valid_d  = in_valid;
    result_d = result_q;
    flag_d   = flag_q;
    err_d    = err_q;
    if (in_valid) begin
      result_d = clamped;
      flag_d   = clip_c;
      err_d    = err_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      flag_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      valid_q  <= valid_d;
      result_q <= result_d;
      flag_q   <= flag_d;
      err_q    <= err_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign sat_flag  = flag_q;
  assign enc_err   = err_q;
endmodule

// File: rtl/shsat_unit_chk.sv
module shsat_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int NPOS_W  = $clog2(DATA_W) + 1,
  parameter int SHAMT_W = $clog2(DATA_W)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               sat_unsigned,
  input logic [NPOS_W-1:0]  sat_width,
  input logic               shift_dir,
  input logic [SHAMT_W-1:0] shift_amt,
  input logic               out_valid,
  input logic [DATA_W-1:0]  result,
  input logic               sat_flag,
  input logic               enc_err
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r4_no_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_unsigned && sat_width != '0) |=> !result[DATA_W-1]);
  a_r8_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_unsigned && sat_width == '0) |=> (result == '0));
  a_r9_full_width: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !sat_unsigned && sat_width == NPOS_W'(DATA_W)) |=> !sat_flag);
  a_r10_zero_right: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shift_dir && shift_amt == '0) |=> enc_err);
endmodule

bind shsat_unit shsat_unit_chk #(.DATA_W(DATA_W), .NPOS_W(NPOS_W), .SHAMT_W(SHAMT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .sat_unsigned (sat_unsigned),
  .sat_width    (sat_width),
  .shift_dir    (shift_dir),
  .shift_amt    (shift_amt),
  .out_valid    (out_valid),
  .result       (result),
  .sat_flag     (sat_flag),
  .enc_err      (enc_err)
);

// File: tb/shsat_unit_tb.sv
`timescale 1ns/1ps
module shsat_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] operand;
  logic        sat_unsigned;
  logic [5:0]  sat_width;
  logic        shift_dir;
  logic [4:0]  shift_amt;
  logic        out_valid;
  logic [31:0] result;
  logic        sat_flag;
  logic        enc_err;

  typedef struct {
    logic [31:0] res;
    logic        flg;
    logic        err;
    string       req;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk;
  int          n_bad;
  logic [31:0] last_res;
  bit          done;

  shsat_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .operand      (operand),
    .sat_unsigned (sat_unsigned),
    .sat_width    (sat_width),
    .shift_dir    (shift_dir),
    .shift_amt    (shift_amt),
    .out_valid    (out_valid),
    .result       (result),
    .sat_flag     (sat_flag),
    .enc_err      (enc_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] op, input logic mu, input logic [5:0] n,
                                 input logic dir, input logic [4:0] amt, input string req);
    exp_t        e;
    longint      sh, lo, hi, v;
    int          nn;
    logic [31:0] t;
    e.err = 1'b0;
    if (dir) begin
      if (amt == 0) begin
        e.err = 1'b1;
        sh = longint'($signed(op));
      end else begin
        t  = $signed(op) >>> amt;
        sh = longint'($signed(t));
      end
    end else begin
      t  = op << amt;
      sh = longint'($signed(t));
    end
    nn = int'(n);
    if (!mu) begin
      if (nn < 1)  begin nn = 1;  e.err = 1'b1; end
      if (nn > 32) begin nn = 32; e.err = 1'b1; end
      lo = -(64'sd1 <<< (nn - 1));
      hi = (64'sd1 <<< (nn - 1)) - 1;
    end else begin
      if (nn > 31) begin nn = 31; e.err = 1'b1; end
      lo = 0;
      hi = (64'sd1 <<< nn) - 1;
    end
    v = (sh < lo) ? lo : ((sh > hi) ? hi : sh);
    e.res = v[31:0];
    e.flg = (v != sh);
    e.req = req;
    return e;
  endfunction

  task automatic send(input logic [31:0] op, input logic mu, input logic [5:0] n,
                      input logic dir, input logic [4:0] amt, input string req);
    exp_t e;
    @(negedge clk);
    in_valid     = 1'b1;
    operand      = op;
    sat_unsigned = mu;
    sat_width    = n;
    shift_dir    = dir;
    shift_amt    = amt;
    e = model(op, mu, n, dir, amt, req);
    sb_q.push_back(e);
    last_res = e.res;
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && out_valid) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R2", 64'(out_valid), 64'd0);
      end else begin
        e = sb_q.pop_front();
        check(result == e.res, e.req, 64'(result), 64'(e.res));
        check(sat_flag == e.flg, {e.req, "/R11"}, 64'(sat_flag), 64'(e.flg));
        check(enc_err == e.err, {e.req, "/R10"}, 64'(enc_err), 64'(e.err));
      end
    end
  end

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    in_valid = 1'b0;
    operand = '0;
    sat_unsigned = 1'b0;
    sat_width = 6'd8;
    shift_dir = 1'b0;
    shift_amt = '0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    check(result == '0, "R1", 64'(result), 64'd0);
    check(sat_flag == 1'b0 && enc_err == 1'b0, "R1", 64'({sat_flag, enc_err}), 64'd0);
    rst_n = 1'b1;

    // R3 signed clamp both directions
    send(32'd1000,      1'b0, 6'd8,  1'b0, 5'd0, "R3");
    send(32'hFFFF_FC00, 1'b0, 6'd8,  1'b0, 5'd0, "R3");
    send(32'd127,       1'b0, 6'd8,  1'b0, 5'd0, "R5");
    send(32'hFFFF_FF80, 1'b0, 6'd8,  1'b0, 5'd0, "R5");
    send(32'd128,       1'b0, 6'd8,  1'b0, 5'd0, "R3");
    send(32'h0000_0001, 1'b0, 6'd1,  1'b0, 5'd0, "R3");
    send(32'hFFFF_FFFF, 1'b0, 6'd1,  1'b0, 5'd0, "R5");
    // R4 unsigned clamp
    send(32'hFFFF_FFFF, 1'b1, 6'd8,  1'b0, 5'd0, "R4");
    send(32'd300,       1'b1, 6'd8,  1'b0, 5'd0, "R4");
    send(32'd255,       1'b1, 6'd8,  1'b0, 5'd0, "R5");
    send(32'h8000_0000, 1'b1, 6'd31, 1'b0, 5'd0, "R4");
    send(32'h7FFF_FFFF, 1'b1, 6'd31, 1'b0, 5'd0, "R4");
    // R6 arithmetic right shift
    send(32'hFFFF_0000, 1'b0, 6'd16, 1'b1, 5'd4,  "R6");
    send(32'h8000_0000, 1'b0, 6'd32, 1'b1, 5'd31, "R6");
    send(32'h0010_0000, 1'b0, 6'd12, 1'b1, 5'd4,  "R6");
    send(32'hF000_0000, 1'b1, 6'd16, 1'b1, 5'd8,  "R6");
    // R7 left shift with wrap
    send(32'h4000_0001, 1'b0, 6'd32, 1'b0, 5'd1,  "R7");
    send(32'h4000_0001, 1'b0, 6'd16, 1'b0, 5'd1,  "R7");
    send(32'h4000_0001, 1'b1, 6'd16, 1'b0, 5'd2,  "R7");
    send(32'h0000_0003, 1'b0, 6'd32, 1'b0, 5'd31, "R7");
    send(32'h0000_0005, 1'b0, 6'd10, 1'b0, 5'd4,  "R7");
    // R8 unsigned n=0
    send(32'd0,         1'b1, 6'd0,  1'b0, 5'd0, "R8");
    send(32'd5,         1'b1, 6'd0,  1'b0, 5'd0, "R8");
    send(32'hFFFF_FFFF, 1'b1, 6'd0,  1'b0, 5'd0, "R8");
    // R9 signed n=32
    send(32'h8000_0000, 1'b0, 6'd32, 1'b0, 5'd0, "R9");
    send(32'h7FFF_FFFF, 1'b0, 6'd32, 1'b0, 5'd0, "R9");
    // R10 illegal encodings
    send(32'hFFFF_FF00, 1'b0, 6'd32, 1'b1, 5'd0, "R10");
    send(32'd1000,      1'b0, 6'd0,  1'b0, 5'd0, "R10");
    send(32'h8000_0000, 1'b0, 6'd40, 1'b0, 5'd0, "R10");
    send(32'hFFFF_FFFF, 1'b1, 6'd32, 1'b0, 5'd0, "R10");
    send(32'h7FFF_FFFF, 1'b1, 6'd63, 1'b0, 5'd0, "R10");

    @(negedge clk);
    in_valid = 1'b0;
    operand  = 32'h1234_5678;
    @(negedge clk);
    @(negedge clk);
    // R2: idle cycles drop out_valid and hold the last result
    check(out_valid == 1'b0, "R2", 64'(out_valid), 64'd0);
    check(result == last_res, "R2", 64'(result), 64'(last_res));
    check(sb_q.size() == 0, "R2", 64'(sb_q.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule